// File: doc/BRIEF.md
# Linked-Access Reservation Monitor

This block lets one core perform an atomic read-modify-write on a small word-addressed memory without locking the bus. The core issues a linked read, which returns the word and places a reservation on its address. Later, the core issues a conditional write to the same address. The write goes through only if nothing has written that word in the meantime. The response to the conditional write is a single-bit verdict, 1 for committed and 0 for refused, which the core places in its destination register.

Writes made by other agents are reported on a snoop port and can break the reservation. The core's own ordinary stores to the reserved word also break it. The core computes the effective address (base register plus a signed 16-bit offset) before it reaches this block, so the block only ever sees a word index. There is a single request channel with a valid/ready handshake. Every accepted request produces one response, valid in the cycle after acceptance.

Top module: `llsc_monitor`

## Requirements
- R1: A linked read (req_op = 2) returns the current word at req_addr on rsp_data one cycle after acceptance, and reserves that address.
- R2: A conditional write (req_op = 3) to the reserved address while the reservation is intact stores req_wdata and returns 1.
- R3: A conditional write with no intact reservation returns 0 and leaves memory unchanged.
- R4: A conditional write to an address other than the reserved one returns 0 and leaves memory unchanged.
- R5: A snoop write to the reserved address cancels the reservation, and a snoop write to any other address leaves it intact.
- R6: An ordinary store (req_op = 1) writes memory and returns 0, and it cancels the reservation when it targets the reserved address.
- R7: Every conditional write clears the reservation, whether it commits or not, so a second one without a new linked read returns 0.
- R8: A new linked read replaces the previous reservation, so only the newest address can be committed.
- R9: A snoop to the same address in the same cycle as a conditional write makes that write fail. The same snoop in the same cycle as a linked read leaves no reservation.
- R10: req_ready is high from the first clock edge after reset is released. Each accepted request gives exactly one rsp_valid pulse in the next cycle, and there is no rsp_valid without an accepted request.
- R11: After reset, rsp_valid and req_ready are low, every word reads 0, and no reservation exists.
- R12: A plain read (req_op = 0) returns the current word and does not disturb the reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 read, 1 store, 2 linked read, 3 conditional write |
| req_addr | input | ADDR_W | Word index (effective address already computed) |
| req_wdata | input | DATA_W | Store data |
| snoop_valid | input | 1 | Another agent wrote a word |
| snoop_addr | input | ADDR_W | Word index written by the other agent |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_data | output | DATA_W | Read data, or 1/0 verdict for a conditional write, or 0 for a store |

## Verification
The bench builds the block with DATA_W = 32 and ADDR_W = 3, which gives only eight words. With so few words, random requests and snoops often land on the reserved address. This exercises same-cycle clashes and the replacement of one reservation by another far more often than a wide address space would. The directed part walks through each ordering corner one at a time. A behavioural model then follows a long random mix of all four request kinds, with snoops, cycle by cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } llsc_op_e;

  // A conditional write commits only on an intact reservation for the same
  // word that no other agent hits in the very same cycle.
  function automatic logic cond_grant(input logic held,
                                      input logic same_word,
                                      input logic snoop_clash);
    return held & same_word & ~snoop_clash;
  endfunction

  // A reservation survives a cycle unless something writes its word.
  function automatic logic keep_hold(input logic held,
                                     input logic store_kill,
                                     input logic snoop_kill);
    return held & ~store_kill & ~snoop_kill;
  endfunction

endpackage

// File: rtl/llsc_word_store.sv
module llsc_word_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  assign rdata = words[addr];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n)
          words[g] <= '0;
        else if (we && (addr == ADDR_W'(g)))
          words[g] <= wdata;
      end
    end
  endgenerate

endmodule

// File: rtl/llsc_reservation.sv
module llsc_reservation
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_set,
  input  logic              cond_seen,
  input  logic              store_seen,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              held,
  output logic [ADDR_W-1:0] held_addr,
  output logic              cond_ok,
  output logic              kill
);
  logic same_word_w;
  logic snoop_clash_w;
  logic snoop_kill_w;
  logic store_kill_w;
  logic held_nx;
  logic [ADDR_W-1:0] addr_nx;

  assign same_word_w   = (held_addr == req_addr);
  assign snoop_clash_w = snoop_valid && (snoop_addr == req_addr);
  assign snoop_kill_w  = snoop_valid && (snoop_addr == held_addr);
  assign store_kill_w  = store_seen && same_word_w;
  assign cond_ok       = cond_grant(held, same_word_w, snoop_clash_w);
  assign kill          = held & (snoop_kill_w | store_kill_w);

  always_comb begin
    held_nx = held;
    addr_nx = held_addr;
    if (link_set) begin
      held_nx = ~snoop_clash_w;
      addr_nx = req_addr;
    end else if (cond_seen) begin
      held_nx = 1'b0;
    end else begin
      held_nx = keep_hold(held, store_kill_w, snoop_kill_w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_addr <= '0;
    end else begin
      held      <= held_nx;
      held_addr <= addr_nx;
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam logic [DATA_W-1:0] VERDICT_ONE = DATA_W'(1);

  function automatic logic [DATA_W-1:0] form_result(input llsc_op_e op,
                                                    input logic [DATA_W-1:0] word,
                                                    input logic ok);
    case (op)
      OP_READ, OP_LINK: return word;
      OP_COND:          return ok ? VERDICT_ONE : '0;
      default:          return '0;
    endcase
  endfunction

  logic              rdy_q;
  logic              accept_w;
  llsc_op_e          op_w;
  logic              is_store_w, is_link_w, is_cond_w;
  logic              cond_ok_w;
  logic              res_kill_w;
  logic              res_valid_w;
  logic [ADDR_W-1:0] res_addr_w;
  logic              mem_we_w;
  logic [DATA_W-1:0] rd_word_w;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign req_ready = rdy_q;

  assign accept_w   = req_valid & rdy_q;
  assign op_w       = llsc_op_e'(req_op);
  assign is_store_w = accept_w && (op_w == OP_STORE);
  assign is_link_w  = accept_w && (op_w == OP_LINK);
  assign is_cond_w  = accept_w && (op_w == OP_COND);

  llsc_reservation #(.ADDR_W(ADDR_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_set   (is_link_w),
    .cond_seen  (is_cond_w),
    .store_seen (is_store_w),
    .req_addr   (req_addr),
    .snoop_valid(snoop_valid),
    .snoop_addr (snoop_addr),
    .held       (res_valid_w),
    .held_addr  (res_addr_w),
    .cond_ok    (cond_ok_w),
    .kill       (res_kill_w)
  );

  assign mem_we_w = is_store_w | (is_cond_w & cond_ok_w);

  llsc_word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we_w),
    .addr (req_addr),
    .wdata(req_wdata),
    .rdata(rd_word_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept_w;
      if (accept_w)
        rsp_data <= form_result(op_w, rd_word_w, cond_ok_w);
    end
  end

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              snoop_valid,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_addr
);
  logic acc;
  logic clash;
  assign acc   = req_valid && req_ready;
  assign clash = snoop_valid && (snoop_addr == req_addr);

  // R10
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R10
  rsp_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);

  // R1
  link_reserves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd2 && !clash) |=> (res_valid && res_addr == $past(req_addr)));

  // R2
  cond_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd3 && res_valid && res_addr == req_addr && !clash)
      |=> (rsp_data == DATA_W'(1)));

  // R3
  cond_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd3 && !(res_valid && res_addr == req_addr)) |=> (rsp_data == '0));

  // R7
  cond_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd3) |=> !res_valid);

  // R5
  snoop_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && res_valid && snoop_addr == res_addr && !(acc && req_op == 2'd2))
      |=> !res_valid);

  // R9
  link_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd2 && clash) |=> !res_valid);

endmodule

bind llsc_monitor llsc_monitor_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .req_addr   (req_addr),
  .snoop_valid(snoop_valid),
  .snoop_addr (snoop_addr),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .res_valid  (res_valid_w),
  .res_addr   (res_addr_w)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;

  always #2 clk = ~clk;

  llsc_monitor #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural model state
  logic [DW-1:0] m_mem [NW];
  bit            m_hold = 0;
  int            m_at = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input int op, input int a, input logic [DW-1:0] d,
                      input bit sv, input int sa, input string tag);
    bit            ev;
    logic [DW-1:0] ed;
    bit            clash;
    req_valid   = v;
    req_op      = 2'(op);
    req_addr    = AW'(a);
    req_wdata   = d;
    snoop_valid = sv;
    snoop_addr  = AW'(sa);
    ev    = v;
    ed    = '0;
    clash = sv && (sa == a);
    if (v) begin
      case (op)
        0: ed = m_mem[a];
        1: begin
             m_mem[a] = d;
             if (m_hold && m_at == a) m_hold = 0;
           end
        2: begin
             ed = m_mem[a];
             m_hold = !clash;
             m_at = a;
           end
        default: begin
             if (m_hold && m_at == a && !clash) begin
               ed = 1;
               m_mem[a] = d;
             end
             m_hold = 0;
           end
      endcase
    end
    if (sv && m_hold && m_at == sa) m_hold = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid   = 1'b0;
    snoop_valid = 1'b0;
    chk({tag, " rsp_valid"}, DW'(rsp_valid), DW'(ev));
    if (ev) chk({tag, " rsp_data"}, rsp_data, ed);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      tests++;
      $display("FAIL R10: watchdog expired, actual %0d expected <= 200000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11 rsp_valid in reset", DW'(rsp_valid), '0);
    chk("R11 req_ready in reset", DW'(req_ready), '0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R10: ready after first edge out of reset
    chk("R10 req_ready", DW'(req_ready), DW'(1));
    chk("R10 idle rsp_valid", DW'(rsp_valid), '0);

    step(1, 0, 5, 0, 0, 0, "R11 word cleared");
    step(1, 3, 2, 32'hDEAD, 0, 0, "R11 no reservation");
    step(1, 0, 2, 0, 0, 0, "R3 no write");
    step(1, 1, 2, 32'hA0A0, 0, 0, "R6 store");
    step(1, 2, 2, 0, 0, 0, "R1 linked read");
    step(1, 0, 2, 0, 0, 0, "R12 plain read");
    step(1, 3, 2, 32'hB1B1, 0, 0, "R2 commit");
    step(1, 0, 2, 0, 0, 0, "R2 word written");
    step(1, 3, 2, 32'hC2C2, 0, 0, "R7 second cond");
    step(1, 0, 2, 0, 0, 0, "R7 unchanged");
    step(1, 2, 3, 0, 0, 0, "R1 linked read");
    step(1, 3, 4, 32'h4444, 0, 0, "R4 other addr");
    step(1, 0, 4, 0, 0, 0, "R4 unchanged");
    step(1, 2, 3, 0, 1, 1, "R5 snoop elsewhere");
    step(0, 0, 0, 0, 1, 6, "R5 idle snoop");
    step(1, 3, 3, 32'h3333, 0, 0, "R5 survives");
    step(1, 2, 3, 0, 0, 0, "R5 relink");
    step(0, 0, 0, 0, 1, 3, "R5 snoop hit");
    step(1, 3, 3, 32'h3A3A, 0, 0, "R5 cancelled");
    step(1, 2, 3, 0, 0, 0, "R6 link");
    step(1, 1, 3, 32'hD0D0, 0, 0, "R6 store hit");
    step(1, 3, 3, 32'hEEEE, 0, 0, "R6 cancelled");
    step(1, 0, 3, 0, 0, 0, "R6 store data");
    step(1, 2, 1, 0, 0, 0, "R8 first link");
    step(1, 2, 6, 0, 0, 0, "R8 second link");
    step(1, 3, 1, 32'h1111, 0, 0, "R8 old addr");
    step(1, 2, 1, 0, 0, 0, "R8 first link");
    step(1, 2, 6, 0, 0, 0, "R8 second link");
    step(1, 3, 6, 32'h6666, 0, 0, "R8 new addr");
    step(1, 2, 0, 0, 0, 0, "R9 link");
    step(1, 3, 0, 32'h0F0F, 1, 0, "R9 clash on cond");
    step(1, 2, 0, 0, 1, 0, "R9 clash on link");
    step(1, 3, 0, 32'hF0F0, 0, 0, "R9 no reservation");
    step(1, 0, 0, 0, 0, 0, "R9 unchanged");
    step(0, 0, 0, 0, 0, 0, "R10 idle");

    for (int k = 0; k < 2000; k++) begin
      bit v;
      bit sv;
      v  = ($urandom_range(0, 9) != 0);
      sv = ($urandom_range(0, 3) == 0);
      step(v, int'($urandom_range(0, 3)), int'($urandom_range(0, NW - 1)),
           DW'($urandom), sv, int'($urandom_range(0, NW - 1)), "R10 random mix");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule